// File: doc/BRIEF.md
# Masked Vector Gather-Scatter Unit

This block moves a 16-lane vector register to or from memory, one lane at a time. Every lane has its own address, so one operation can touch up to sixteen unrelated memory locations. A gather reads from memory into the vector, and a scatter writes the vector out to memory.

A per-lane predicate mask chooses which lanes take part. A lane whose mask bit is clear gets no memory access. On a gather, that lane keeps its old destination contents. Because of this, a branch-free if-then-else can be written as two operations with complementary masks. Each lane holds a payload of raw bits, which can be integer, single-precision or double-precision data. The element size is either 64 bits, or 32 bits carried in the low half of each lane.

The unit drives a single-port memory with a request/ready handshake and makes at most one element request per cycle. Read data comes back exactly one cycle after the request is accepted. When every active lane has finished, the unit gives a one-cycle completion pulse and holds the assembled vector on its result output.

Top module: `gs_unit`

## Requirements
- R1: Active lanes are served in strictly ascending lane index order. The n-th accepted memory request carries the address of the n-th set mask bit, counting from bit 0.
- R2: A lane whose mask bit is 0 produces no memory request. The number of accepted requests equals the number of set mask bits, and no request is raised while `busy` is low.
- R3: On a gather (`is_store`=0), an active lane's result is the memory word at its address when `elem64`=1. When `elem64`=0, the lane's result bits [31:0] take the memory word's bits [31:0] and its bits [63:32] keep the value given on `vec_in`.
- R4: On a gather, an inactive lane's result equals its `vec_in` value, which is the previous destination contents.
- R5: On a scatter (`is_store`=1), each request has `mem_we`=1 and `mem_wdata` equal to the lane's `vec_in` value. `mem_wide` equals `elem64`, so memory stores all 64 bits or only bits [31:0].
- R6: On a scatter where several active lanes share one address, the memory ends up holding the value of the highest-numbered of those lanes.
- R7: With an all-zero mask, `done` is high in the second cycle after the cycle in which `start` is sampled high, and no memory request is made.
- R8: `done` is a single-cycle pulse, given exactly once per accepted operation. It rises one cycle after the last handshake, with `busy` already low.
- R9: While `mem_req` is high and `mem_ready` is low, the request stays raised in the next cycle with unchanged `mem_addr` and `mem_wdata`.
- R10: A `start` pulse while `busy` is high is ignored. It does not change the running operation's requests or its result.
- R11: After reset, `busy`, `done` and `mem_req` are 0 and `vec_out` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| is_store | input | 1 | 1 = scatter, 0 = gather |
| elem64 | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| mask | input | LANES | Per-lane predicate; bit i enables lane i |
| addr_vec | input | LANES*ADDR_W | Lane i address at bits [i*ADDR_W +: ADDR_W] |
| vec_in | input | LANES*DATA_W | Store data or previous destination contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vec_out | output | LANES*DATA_W | Assembled vector register |
| mem_req | output | 1 | Element request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 64-bit access, 0 = low 32 bits |
| mem_addr | output | ADDR_W | Element address |
| mem_wdata | output | DATA_W | Element write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DATA_W | Read data, valid one cycle after acceptance |

## Verification
The bench builds the unit with the default 16 lanes and 64-bit lanes, but narrows ADDR_W to 8. A 256-word memory model then stands in for the whole address space, so random lane addresses often collide. That makes the scatter write-order rule and repeated gathers from one word show up without being forced. A random ready pattern stretches the handshake so that held requests and back-to-back acceptances both occur.

// File: rtl/gs_pkg.sv
// Package: shared types for the gather-scatter unit.
// Assumes nothing beyond being compiled before the modules that import it.
package gs_pkg;
    typedef enum logic {
        GS_IDLE = 1'b0,
        GS_RUN  = 1'b1
    } gs_state_e;
endpackage

// File: rtl/gs_lane_picker.sv
// Lane picker: finds the lowest-numbered lane still pending.
// Assumes pending is a plain bit vector; purely combinational.
module gs_lane_picker #(
    parameter int LANES = 16,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pending,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Priority encode, scanning from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/gs_elem_bank.sv
// Element bank: per-lane vector storage. Loaded whole at operation start
// and updated one lane at a time as gather data returns. In 32-bit mode
// only the low half of the lane is replaced.
module gs_elem_bank #(
    parameter int LANES  = 16,
    parameter int DATA_W = 64,
    localparam int IDX_W  = $clog2(LANES),
    localparam int HALF_W = DATA_W / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [LANES*DATA_W-1:0] load_data,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_lane,
    input  logic                    wr_wide,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [LANES*DATA_W-1:0] lanes_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] elem_q;
        // Hold one lane: bulk load on start, partial or full write on return.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                elem_q <= '0;
            end else if (load_en) begin
                elem_q <= load_data[g*DATA_W +: DATA_W];
            end else if (wr_en && wr_lane == IDX_W'(g)) begin
                if (wr_wide) elem_q <= wr_data;
                else         elem_q[HALF_W-1:0] <= wr_data[HALF_W-1:0];
            end
        end
        assign lanes_out[g*DATA_W +: DATA_W] = elem_q;
    end
endmodule

// File: rtl/gs_seq.sv
// Sequencer: accepts an operation, walks the pending lanes through the
// memory handshake and tracks the one-cycle read return. Assumes read data
// arrives exactly one cycle after acceptance.
module gs_seq #(
    parameter int LANES = 16,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_store,
    input  logic             elem64,
    input  logic [LANES-1:0] mask,
    input  logic             pick_found,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             mem_ready,
    output logic [LANES-1:0] pending,
    output logic             load_en,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_wide,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_lane
);
    import gs_pkg::*;

    gs_state_e state_q;
    logic      store_q, wide_q, done_q, rdv_q;
    logic [IDX_W-1:0] rdl_q;
    logic      accept;

    // Request whenever running with a lane left; handshake completes on ready.
    always_comb begin
        mem_req = (state_q == GS_RUN) && pick_found;
        accept  = mem_req && mem_ready;
        load_en = (state_q == GS_IDLE) && start;
    end

    // Operation state, pending lanes and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            pending <= '0;
            store_q <= 1'b0;
            wide_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                GS_IDLE: if (start) begin
                    state_q <= GS_RUN;
                    pending <= mask;
                    store_q <= is_store;
                    wide_q  <= elem64;
                end
                GS_RUN: begin
                    if (accept) pending[pick_idx] <= 1'b0;
                    if (!pick_found) begin
                        state_q <= GS_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end

    // Remember which lane a read was accepted for, to steer the return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdv_q <= 1'b0;
            rdl_q <= '0;
        end else begin
            rdv_q <= accept && !store_q;
            if (accept) rdl_q <= pick_idx;
        end
    end

    assign busy     = (state_q == GS_RUN);
    assign done     = done_q;
    assign mem_we   = store_q;
    assign mem_wide = wide_q;
    assign rd_valid = rdv_q;
    assign rd_lane  = rdl_q;
endmodule

// File: rtl/gs_unit.sv
// Gather-scatter unit top: latches lane addresses, ties the sequencer,
// lane picker and element bank together, and muxes the chosen lane onto
// the memory port. Assumes a single-port memory with 1-cycle read latency.
module gs_unit #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     is_store,
    input  logic                     elem64,
    input  logic [LANES-1:0]         mask,
    input  logic [LANES*ADDR_W-1:0]  addr_vec,
    input  logic [LANES*DATA_W-1:0]  vec_in,
    output logic                     busy,
    output logic                     done,
    output logic [LANES*DATA_W-1:0]  vec_out,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic                     mem_wide,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic                     mem_ready,
    input  logic [DATA_W-1:0]        mem_rdata
);
    localparam int IDX_W = $clog2(LANES);

    logic [LANES-1:0] pending;
    logic             pick_found, load_en, rd_valid;
    logic [IDX_W-1:0] pick_idx, rd_lane;
    logic [ADDR_W-1:0] addr_q [LANES];

    gs_seq #(.LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .elem64(elem64), .mask(mask), .pick_found(pick_found),
        .pick_idx(pick_idx), .mem_ready(mem_ready), .pending(pending),
        .load_en(load_en), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wide(mem_wide), .rd_valid(rd_valid),
        .rd_lane(rd_lane)
    );

    gs_lane_picker #(.LANES(LANES)) u_pick (
        .pending(pending), .found(pick_found), .idx(pick_idx)
    );

    gs_elem_bank #(.LANES(LANES), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(vec_in),
        .wr_en(rd_valid), .wr_lane(rd_lane), .wr_wide(mem_wide),
        .wr_data(mem_rdata), .lanes_out(vec_out)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_addr
        // Capture this lane's address when an operation is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n)       addr_q[g] <= '0;
            else if (load_en) addr_q[g] <= addr_vec[g*ADDR_W +: ADDR_W];
        end
    end

    // Present the picked lane's address and store data on the port.
    always_comb begin
        mem_addr  = addr_q[pick_idx];
        mem_wdata = vec_out[pick_idx*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/gs_unit_chk.sv
// Checker for gs_unit: handshake hold, pulse shape, idle quietness,
// empty-mask timing and ascending lane service. Bound into every gs_unit.
module gs_unit_chk #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [LANES-1:0]  mask,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [IDX_W-1:0]  cur_lane
);
    logic             have_last;
    logic [IDX_W-1:0] last_lane;

    // Track the lane served by the previous handshake of this operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_lane <= '0;
        end else if (start && !busy) begin
            have_last <= 1'b0;
        end else if (mem_req && mem_ready) begin
            have_last <= 1'b1;
            last_lane <= cur_lane;
        end
    end

    assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && have_last) |-> (cur_lane > last_lane));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_empty_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mask == '0) |=> !mem_req ##1 done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind gs_unit gs_unit_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mask(mask), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_lane(pick_idx)
);

// File: tb/gs_unit_tb.sv
module gs_unit_tb;
    localparam int L  = 16;
    localparam int AW = 8;
    localparam int DW = 64;
    localparam int MD = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, is_store = 0, elem64 = 0, mem_ready = 0;
    logic [L-1:0] mask = '0;
    logic [L*AW-1:0] addr_vec = '0;
    logic [L*DW-1:0] vec_in = '0, vec_out;
    logic busy, done, mem_req, mem_we, mem_wide;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata = '0;

    logic [DW-1:0] mem [MD];
    logic [DW-1:0] ref_mem [MD];
    logic [AW-1:0] exp_addr [L];
    logic [DW-1:0] exp_wd [L];
    int exp_n, acc_cnt, seq_err, n_chk = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    gs_unit #(.LANES(L), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .elem64(elem64), .mask(mask), .addr_vec(addr_vec), .vec_in(vec_in),
        .busy(busy), .done(done), .vec_out(vec_out), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model and request monitor.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ready) begin
            if (acc_cnt >= exp_n || mem_addr != exp_addr[acc_cnt]) seq_err++;
            else if (is_store && (!mem_we || mem_wide != elem64 || mem_wdata != exp_wd[acc_cnt])) seq_err++;
            acc_cnt++;
            if (mem_we) begin
                if (mem_wide) mem[mem_addr] <= mem_wdata;
                else          mem[mem_addr][31:0] <= mem_wdata[31:0];
            end else begin
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    always @(negedge clk) mem_ready <= ($urandom % 10) < 7;

    always @(negedge clk) if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual cyc=%0d expected < 150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane_expect(input bit st, input bit wide, input bit act,
                                                   input logic [DW-1:0] old, input logic [DW-1:0] m);
        if (st || !act) return old;
        if (wide) return m;
        return {old[DW-1:32], m[31:0]};
    endfunction

    task automatic run_op(input bit st, input bit wide, input logic [L-1:0] mk, input bit poke);
        logic [L*DW-1:0] exp_vec;
        int waited = 0, bad_mem = 0;
        exp_n = 0;
        for (int i = 0; i < L; i++) begin
            logic [AW-1:0] a = addr_vec[i*AW +: AW];
            logic [DW-1:0] d = vec_in[i*DW +: DW];
            exp_vec[i*DW +: DW] = lane_expect(st, wide, mk[i], d, ref_mem[a]);
            if (mk[i]) begin
                exp_addr[exp_n] = a; exp_wd[exp_n] = d; exp_n++;
                if (st) begin
                    if (wide) ref_mem[a] = d;
                    else ref_mem[a][31:0] = d[31:0];
                end
            end
        end
        @(negedge clk);
        acc_cnt = 0; seq_err = 0;
        start = 1; is_store = st; elem64 = wide; mask = mk;
        @(negedge clk);
        start = poke; mask = ~mk;
        @(negedge clk);
        start = 0;
        while (!done && waited < 400) begin @(negedge clk); waited++; end
        chk(done, "R8 done seen", {63'd0, done}, 64'd1);
        @(negedge clk);
        chk(!done, "R8 single pulse", {63'd0, done}, 64'd0);
        chk(seq_err == 0 && acc_cnt == exp_n, "R1/R2/R5 request sequence",
            64'(acc_cnt), 64'(exp_n));
        if (poke) chk(acc_cnt == exp_n, "R10 start while busy ignored", 64'(acc_cnt), 64'(exp_n));
        for (int i = 0; i < L; i++)
            chk(vec_out[i*DW +: DW] == exp_vec[i*DW +: DW],
                mk[i] ? "R3 active lane" : "R4 inactive lane",
                vec_out[i*DW +: DW], exp_vec[i*DW +: DW]);
        for (int a = 0; a < MD; a++) if (mem[a] != ref_mem[a]) bad_mem++;
        chk(bad_mem == 0, "R5/R6 memory image", 64'(bad_mem), 64'd0);
    endtask

    task automatic rand_vec();
        for (int i = 0; i < L; i++) begin
            addr_vec[i*AW +: AW] = AW'($urandom);
            vec_in[i*DW +: DW] = {$urandom, $urandom};
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int a = 0; a < MD; a++) begin
            mem[a] = {$urandom, $urandom};
            ref_mem[a] = mem[a];
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && vec_out == '0, "R11 reset state",
            {61'd0, busy, done, mem_req}, 64'd0);
        rst_n = 1;

        // R7: empty mask, done exactly two cycles after start sample.
        rand_vec();
        @(negedge clk);
        start = 1; mask = '0; is_store = 0; acc_cnt = 0; exp_n = 0; seq_err = 0;
        @(negedge clk); start = 0;
        chk(!done && !mem_req, "R7 no early done", {62'd0, done, mem_req}, 64'd0);
        @(negedge clk);
        chk(done && acc_cnt == 0, "R7 done after empty mask", {63'd0, done}, 64'd1);
        chk(vec_out == vec_in, "R4 empty mask keeps vector", vec_out[63:0], vec_in[63:0]);

        // R6: all lanes scatter to one address; lane 15 wins.
        rand_vec();
        for (int i = 0; i < L; i++) addr_vec[i*AW +: AW] = 8'h5A;
        run_op(1, 1, 16'hFFFF, 0);
        chk(mem[8'h5A] == vec_in[15*DW +: DW], "R6 highest lane wins",
            mem[8'h5A], vec_in[15*DW +: DW]);

        // R3/R4: if-then-else via complementary masks, 32-bit then 64-bit.
        rand_vec();
        run_op(0, 0, 16'hA5C3, 0);
        vec_in = vec_out;
        run_op(0, 1, ~16'hA5C3, 0);

        // R5: 32-bit scatter keeps upper memory halves.
        rand_vec();
        run_op(1, 0, 16'h0F0F, 0);

        // R10: start pulse during a running gather.
        rand_vec();
        run_op(0, 1, 16'h8001, 1);

        // Random mix.
        for (int k = 0; k < 60; k++) begin
            rand_vec();
            run_op($urandom % 2, $urandom % 2, L'($urandom), ($urandom % 4) == 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule